// File: doc/BRIEF.md
# Fault-Injectable Lookup Table Cell

This block is a lookup table of one to four inputs. Its truth table sits in a 16-bit register loaded through a synchronous configuration port, together with the number of inputs in use. The output is a purely combinational function of the data inputs and the registered state. Inputs above the active count play no part in the result. The block is meant to stand in for an ordinary logic cell inside a design under reliability study, so that the design can be exercised while one of its cells misbehaves in a controlled way.

A registered fault-control port lets the surrounding test environment corrupt the cell at run time in three ways:

- Invert truth-table bits: one bit chosen by index, or several bits chosen by a pattern. Only bits inside the part of the table that the active input count can reach are ever affected.
- Hold one chosen input at a constant level.
- Hold the output at a constant level.

Top module: `lutfi_cell`

## Requirements
- R1: After reset the table holds all zeros, the active input count is four and no fault is armed, so `lut_out` is 0 for every input value.
- R2: With no fault in effect, `lut_out` equals table bit number k. Here k is formed from `lut_in` bits 0 to n-1, with bit 0 as the least significant bit, and n is the active input count. Bits of `lut_in` at position n and above are ignored.
- R3: `cfg_table` and `cfg_width` are captured at the rising clock edge where `cfg_load` is 1, and held otherwise. `cfg_width` gives n directly for values 1 to 4; a value of 0 is taken as 1, and 5 to 7 are taken as 4.
- R4: `flt_kind` is encoded as 0 = none, 1 = table bit flip, 2 = input stuck, 3 = output stuck. When the captured `flt_enable` is 0, or the kind is 0, the cell behaves as in R2.
- R5: For a single flip (`flt_multi` = 0), table bit `flt_target` is inverted before the lookup, and no other bit changes.
- R6: A single-flip target at or above 2^n is ignored, and the cell behaves as in R2.
- R7: For a multi flip (`flt_multi` = 1), every table bit whose `flt_pattern` bit is 1 is inverted. Pattern bits at positions 2^n and above are dropped.
- R8: For an input stuck fault, input number `flt_target` is forced to `flt_level` before the lookup. A target at or above n is ignored.
- R9: For an output stuck fault, `lut_out` equals `flt_level` whatever the table and the inputs hold.
- R10: All fault-control fields are captured together at the rising edge where `flt_load` is 1. Changes on them while `flt_load` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lut_in | input | 4 | Table address inputs, bit 0 least significant |
| cfg_load | input | 1 | Capture strobe for table contents and width |
| cfg_table | input | 16 | Truth-table contents to capture |
| cfg_width | input | 3 | Number of inputs in use (clamped to 1..4) |
| flt_load | input | 1 | Capture strobe for the fault-control fields |
| flt_enable | input | 1 | Arms the captured fault |
| flt_kind | input | 2 | Fault kind: 0 none, 1 flip, 2 input stuck, 3 output stuck |
| flt_target | input | 4 | Table bit index (flip) or input index (input stuck) |
| flt_multi | input | 1 | Selects the pattern rather than the single index for flips |
| flt_pattern | input | 16 | Bits to invert in multi-flip mode |
| flt_level | input | 1 | Forced level for stuck faults |
| lut_out | output | 1 | Combinational result |

## Verification
The assertions treat the two capture strobes as ordinary synchronous inputs that are stable around the clock edge. They also assume that the captured fault fields change only on a `flt_load` edge. The bench drives every strobe and field on the falling edge and releases the strobes one cycle later, so each capture happens at exactly one rising edge. It samples `lut_out` only between edges, after the inputs have settled. Every table configuration is swept across all sixteen input values, so inputs above the active count are toggled too.

// File: rtl/lutfi_pkg.sv
package lutfi_pkg;
  localparam int LUT_MAX_IN = 4;
  localparam int INIT_W     = 1 << LUT_MAX_IN;
  localparam int TGT_W      = $clog2(INIT_W);
  localparam int NW         = $clog2(LUT_MAX_IN + 1);

  typedef enum logic [1:0] {
    FK_NONE      = 2'd0,
    FK_FLIP      = 2'd1,
    FK_STUCK_IN  = 2'd2,
    FK_STUCK_OUT = 2'd3
  } fault_kind_e;

  // Legal input count: 0 becomes 1, anything above the maximum becomes the maximum.
  function automatic logic [NW-1:0] clamp_width(input logic [NW-1:0] n);
    if (n == '0) return NW'(1);
    if (int'(n) > LUT_MAX_IN) return NW'(LUT_MAX_IN);
    return n;
  endfunction

  // Table bits reachable with n inputs: the lowest 2^n positions.
  function automatic logic [INIT_W-1:0] table_span(input logic [NW-1:0] n);
    logic [INIT_W-1:0] s;
    for (int b = 0; b < INIT_W; b++) s[b] = (b < (1 << int'(n)));
    return s;
  endfunction

  // Inputs in use with n inputs: the lowest n.
  function automatic logic [LUT_MAX_IN-1:0] input_span(input logic [NW-1:0] n);
    logic [LUT_MAX_IN-1:0] s;
    for (int i = 0; i < LUT_MAX_IN; i++) s[i] = (i < int'(n));
    return s;
  endfunction

  function automatic logic [INIT_W-1:0] onehot_at(input logic [TGT_W-1:0] t);
    logic [INIT_W-1:0] r;
    r    = '0;
    r[t] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/lutfi_cfg.sv
module lutfi_cfg
  import lutfi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INIT_W-1:0] table_d,
  input  logic [NW-1:0]     width_d,
  output logic [INIT_W-1:0] table_q,
  output logic [NW-1:0]     width_q,
  output logic [INIT_W-1:0] tbl_span,
  output logic [LUT_MAX_IN-1:0] in_span
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      table_q <= '0;
      width_q <= NW'(LUT_MAX_IN);
    end else if (load) begin
      table_q <= table_d;
      width_q <= clamp_width(width_d);
    end
  end

  assign tbl_span = table_span(width_q);
  assign in_span  = input_span(width_q);

  a_r3_table_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> table_q == $past(table_d));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(table_q) && $stable(width_q));
  a_r3_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
    width_q != '0 && int'(width_q) <= LUT_MAX_IN);
endmodule

// File: rtl/lutfi_fault.sv
module lutfi_fault
  import lutfi_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  enable_d,
  input  logic [1:0]            kind_d,
  input  logic [TGT_W-1:0]      target_d,
  input  logic                  multi_d,
  input  logic [INIT_W-1:0]     pattern_d,
  input  logic                  level_d,
  input  logic [INIT_W-1:0]     tbl_span,
  input  logic [LUT_MAX_IN-1:0] in_span,
  output logic [INIT_W-1:0]     flip_mask,
  output logic [LUT_MAX_IN-1:0] in_force,
  output logic                  out_force,
  output logic                  force_level
);
  logic                  en_q;
  fault_kind_e           kind_q;
  logic [TGT_W-1:0]      tgt_q;
  logic                  multi_q;
  logic [INIT_W-1:0]     pat_q;
  logic                  lvl_q;
  logic                  flip_on, stin_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      kind_q  <= FK_NONE;
      tgt_q   <= '0;
      multi_q <= 1'b0;
      pat_q   <= '0;
      lvl_q   <= 1'b0;
    end else if (load) begin
      en_q    <= enable_d;
      kind_q  <= fault_kind_e'(kind_d);
      tgt_q   <= target_d;
      multi_q <= multi_d;
      pat_q   <= pattern_d;
      lvl_q   <= level_d;
    end
  end

  assign flip_on     = en_q && (kind_q == FK_FLIP);
  assign stin_on     = en_q && (kind_q == FK_STUCK_IN);
  assign out_force   = en_q && (kind_q == FK_STUCK_OUT);
  assign force_level = lvl_q;

  // Mask is confined to the reachable table bits in both modes.
  assign flip_mask = !flip_on ? '0
                   : (multi_q ? pat_q : onehot_at(tgt_q)) & tbl_span;

  generate
    for (genvar i = 0; i < LUT_MAX_IN; i++) begin : g_force
      assign in_force[i] = stin_on && (int'(tgt_q) == i) && in_span[i];
    end
  endgenerate

  a_r5_single_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !multi_q |-> $onehot0(flip_mask));
  a_r7_mask_in_span: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_mask & ~tbl_span) == '0);
  a_r4_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (flip_mask == '0) && (in_force == '0) && !out_force);
  a_r8_one_input: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_force) && ((in_force & ~in_span) == '0));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(en_q) && $stable(kind_q) && $stable(tgt_q) && $stable(pat_q));
endmodule

// File: rtl/lutfi_eval.sv
module lutfi_eval
  import lutfi_pkg::*;
(
  input  logic [LUT_MAX_IN-1:0] din,
  input  logic [LUT_MAX_IN-1:0] in_span,
  input  logic [INIT_W-1:0]     table_q,
  input  logic [INIT_W-1:0]     flip_mask,
  input  logic [LUT_MAX_IN-1:0] in_force,
  input  logic                  out_force,
  input  logic                  force_level,
  output logic                  dout,
  output logic [LUT_MAX_IN-1:0] addr
);
  logic [LUT_MAX_IN-1:0] used;
  logic [INIT_W-1:0]     eff_table;

  assign used      = din & in_span;
  assign addr      = (used & ~in_force) | (in_force & {LUT_MAX_IN{force_level}});
  assign eff_table = table_q ^ flip_mask;
  assign dout      = out_force ? force_level : eff_table[addr];
endmodule

// File: rtl/lutfi_cell.sv
module lutfi_cell
  import lutfi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  lut_in,
  input  logic        cfg_load,
  input  logic [15:0] cfg_table,
  input  logic [2:0]  cfg_width,
  input  logic        flt_load,
  input  logic        flt_enable,
  input  logic [1:0]  flt_kind,
  input  logic [3:0]  flt_target,
  input  logic        flt_multi,
  input  logic [15:0] flt_pattern,
  input  logic        flt_level,
  output logic        lut_out
);
  logic [INIT_W-1:0]     table_q, tbl_span, flip_mask;
  logic [NW-1:0]         width_q;
  logic [LUT_MAX_IN-1:0] in_span, in_force, addr;
  logic                  out_force, force_level;

  lutfi_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .table_d(cfg_table), .width_d(cfg_width),
    .table_q(table_q), .width_q(width_q),
    .tbl_span(tbl_span), .in_span(in_span)
  );

  lutfi_fault u_fault (
    .clk(clk), .rst_n(rst_n), .load(flt_load),
    .enable_d(flt_enable), .kind_d(flt_kind), .target_d(flt_target),
    .multi_d(flt_multi), .pattern_d(flt_pattern), .level_d(flt_level),
    .tbl_span(tbl_span), .in_span(in_span),
    .flip_mask(flip_mask), .in_force(in_force),
    .out_force(out_force), .force_level(force_level)
  );

  lutfi_eval u_eval (
    .din(lut_in), .in_span(in_span), .table_q(table_q),
    .flip_mask(flip_mask), .in_force(in_force),
    .out_force(out_force), .force_level(force_level),
    .dout(lut_out), .addr(addr)
  );

  a_r9_out_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    out_force |-> lut_out == force_level);
  a_r2_upper_inputs_off: assert property (@(posedge clk) disable iff (!rst_n)
    (addr & ~in_span) == '0);
  a_r2_addr_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    (in_force == '0) |-> addr == (lut_in & in_span));
endmodule

// File: tb/sim_lutfi_cell.sv
`timescale 1ns/1ps
module sim_lutfi_cell;
  typedef struct packed {
    logic [3:0]  tag;
    logic [15:0] tbl;
    logic [2:0]  wid;
    logic [1:0]  kind;
    logic        en;
    logic        multi;
    logic [3:0]  tgt;
    logic [15:0] pat;
    logic        lvl;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 16'hA5C3, 3'd4, 2'd0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0}, // R2
    '{4'd2, 16'h6996, 3'd3, 2'd0, 1'b1, 1'b0, 4'd0,  16'h0000, 1'b0}, // R2
    '{4'd2, 16'h00F2, 3'd1, 2'd0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0}, // R2
    '{4'd5, 16'h1234, 3'd4, 2'd1, 1'b1, 1'b0, 4'd13, 16'h0000, 1'b0}, // R5
    '{4'd5, 16'hFFF8, 3'd2, 2'd1, 1'b1, 1'b0, 4'd2,  16'h0000, 1'b0}, // R5
    '{4'd6, 16'h5A5A, 3'd3, 2'd1, 1'b1, 1'b0, 4'd8,  16'h0000, 1'b0}, // R6
    '{4'd7, 16'h0F0F, 3'd3, 2'd1, 1'b1, 1'b1, 4'd0,  16'hF00F, 1'b0}, // R7
    '{4'd4, 16'hBEEF, 3'd4, 2'd1, 1'b0, 1'b0, 4'd0,  16'hFFFF, 1'b1}, // R4
    '{4'd8, 16'hC0DE, 3'd4, 2'd2, 1'b1, 1'b0, 4'd1,  16'h0000, 1'b1}, // R8
    '{4'd8, 16'h7171, 3'd2, 2'd2, 1'b1, 1'b0, 4'd3,  16'h0000, 1'b0}, // R8
    '{4'd9, 16'h0000, 3'd4, 2'd3, 1'b1, 1'b0, 4'd0,  16'h0000, 1'b1}, // R9
    '{4'd9, 16'hFFFF, 3'd3, 2'd3, 1'b1, 1'b0, 4'd0,  16'h0000, 1'b0}, // R9
    '{4'd3, 16'h0002, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0}, // R3
    '{4'd3, 16'h8001, 3'd7, 2'd0, 1'b0, 1'b0, 4'd0,  16'h0000, 1'b0}  // R3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] lut_in = '0;
  logic cfg_load = 1'b0, flt_load = 1'b0, flt_enable = 1'b0, flt_multi = 1'b0, flt_level = 1'b0;
  logic [15:0] cfg_table = '0, flt_pattern = '0;
  logic [2:0] cfg_width = '0;
  logic [1:0] flt_kind = '0;
  logic [3:0] flt_target = '0;
  logic lut_out;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lutfi_cell u0 (
    .clk(clk), .rst_n(rst_n), .lut_in(lut_in), .cfg_load(cfg_load),
    .cfg_table(cfg_table), .cfg_width(cfg_width), .flt_load(flt_load),
    .flt_enable(flt_enable), .flt_kind(flt_kind), .flt_target(flt_target),
    .flt_multi(flt_multi), .flt_pattern(flt_pattern), .flt_level(flt_level),
    .lut_out(lut_out)
  );

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Reference written from the requirements: walk the truth table by weights.
  function automatic logic model(input vec_t v, input logic [3:0] din);
    int n, k, w;
    logic [15:0] t;
    logic [3:0] d;
    n = (v.wid == 0) ? 1 : ((v.wid > 4) ? 4 : int'(v.wid));
    w = 1 << n;
    t = v.tbl;
    d = din;
    if (v.en) begin
      if (v.kind == 2'd3) return v.lvl;
      if (v.kind == 2'd1) begin
        if (v.multi) begin
          for (int b = 0; b < w; b++) if (v.pat[b]) t[b] = ~t[b];
        end else if (int'(v.tgt) < w) t[v.tgt] = ~t[v.tgt];
      end
      if (v.kind == 2'd2 && int'(v.tgt) < n) d[v.tgt] = v.lvl;
    end
    k = 0;
    for (int i = 0; i < n; i++) k += d[i] ? (1 << i) : 0;
    return t[k];
  endfunction

  task automatic check(input string req, input logic exp, input string what);
    total++;
    if (lut_out !== exp) begin
      bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, lut_out, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    cfg_load = 1'b1; cfg_table = v.tbl; cfg_width = v.wid;
    flt_load = 1'b1; flt_enable = v.en; flt_kind = v.kind; flt_target = v.tgt;
    flt_multi = v.multi; flt_pattern = v.pat; flt_level = v.lvl;
    @(negedge clk);
    cfg_load = 1'b0; flt_load = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state gives 0 everywhere
    for (int d = 0; d < 16; d++) begin
      lut_in = 4'(d); #2;
      check("R1", 1'b0, $sformatf("reset in=%0d", d));
    end

    // Vector table, each swept over every input value
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      for (int d = 0; d < 16; d++) begin
        lut_in = 4'(d); #2;
        check(tag_name(VECS[i].tag), model(VECS[i], 4'(d)), $sformatf("vec %0d in=%0d", i, d));
      end
    end

    // R3: fields change without the strobe -> table unchanged
    v = '{4'd3, 16'h0001, 3'd4, 2'd0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b0};
    apply(v);
    @(negedge clk);
    cfg_table = 16'hFFFE; cfg_width = 3'd1;
    @(negedge clk);
    lut_in = 4'd0; #2; check("R3", 1'b1, "no-load table bit0");
    lut_in = 4'd2; #2; check("R3", 1'b0, "no-load width kept");

    // R10: fault fields change without the strobe -> no effect, then strobe applies
    @(negedge clk);
    flt_enable = 1'b1; flt_kind = 2'd3; flt_level = 1'b1;
    @(negedge clk);
    lut_in = 4'd4; #2; check("R10", 1'b0, "unloaded stuck-out");
    @(negedge clk);
    flt_load = 1'b1;
    @(negedge clk);
    flt_load = 1'b0;
    lut_in = 4'd4; #2; check("R10", 1'b1, "loaded stuck-out");

    // R4: kind none while enabled -> fault-free
    @(negedge clk);
    flt_load = 1'b1; flt_kind = 2'd0;
    @(negedge clk);
    flt_load = 1'b0;
    lut_in = 4'd0; #2; check("R4", 1'b1, "kind none armed");

    // R5: bit 15 flip at the top boundary
    @(negedge clk);
    flt_load = 1'b1; flt_kind = 2'd1; flt_multi = 1'b0; flt_target = 4'd15;
    @(negedge clk);
    flt_load = 1'b0;
    lut_in = 4'd15; #2; check("R5", 1'b1, "flip bit 15");
    lut_in = 4'd0;  #2; check("R5", 1'b1, "bit 0 untouched");

    // R1: reset clears state again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lut_in = 4'd0; #2; check("R1", 1'b0, "re-reset in=0");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule